// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

This block collects message-signalled interrupts that arrive as data writes to a single doorbell register. It splits the written data word into two fields. The low `SHIFT` bits pick one of several 32-bit pending registers. The remaining upper bits pick a vector slot inside that register. The decoded slot is set and stays set. Each pending register drives its own level interrupt line towards the interrupt controller.

Software services an interrupt line by reading the matching pending register over a simple 32-bit register bus. The bus has separate read and write strobes, so a doorbell write and a software read can happen in the same cycle. A read returns the pending bits in big-endian byte order and clears them. A doorbell bit that lands in the same cycle as the clear is kept.

The `SHIFT` parameter sets the register count: 3 gives eight registers, and 2 gives four. The `NARROW` parameter is used only with `SHIFT` = 2. In narrow mode each register owns one 8-bit slice and the registers are placed higher in the map.

Top module: `msi_doorbell_agg`

## Requirements
- R1: A doorbell write (`bus_we` high with `bus_waddr` = 0) is decoded as follows. `bus_wdata[SHIFT-1:0]` selects register k, and `bus_wdata[31:SHIFT]` is the slot number n. There are 2^SHIFT registers. At most one pending bit is set per write.
- R2: In normal mode, slot n of register k sets bit 31-n of that register. Set bits accumulate until they are read.
- R3: Register k is read at byte offset 4+4k in normal mode and 0x10+4k in narrow mode. `bus_rdata` is valid in the cycle after `bus_re`. The value is byte-reversed: `bus_rdata[31:24]` carries register bits 7:0, and `bus_rdata[7:0]` carries register bits 31:24.
- R4: A read of register k returns its old contents and clears it. If a doorbell write for register k arrives in the same cycle, its bit survives the clear and appears in the next read.
- R5: `irq[k]` is high exactly while register k holds at least one set bit. It rises in the cycle after the doorbell write and falls in the cycle after the clearing read.
- R6: In narrow mode (`NARROW`=1, `SHIFT`=2), slots 0..7 are valid. Slot n of register k sets bit 31-8k-n. No bit outside that slice is ever set.
- R7: A doorbell write with n of 32 or more (normal mode) or 8 or more (narrow mode) changes no register. It raises `db_err` for exactly one cycle, in the cycle after the write.
- R8: Reads of offset 0 and of unmapped offsets return zero and clear nothing. Bus writes to any offset other than 0 are ignored.
- R9: Synchronous active-high `rst` clears every register, `irq` and `db_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_waddr | input | AW | Write byte address |
| bus_wdata | input | 32 | Write data (doorbell vector word) |
| bus_re | input | 1 | Single-cycle read strobe |
| bus_raddr | input | AW | Read byte address |
| bus_rdata | output | 32 | Read data, byte-reversed, one cycle after `bus_re` |
| irq | output | 2^SHIFT | Per-register level interrupt lines |
| db_err | output | 1 | One-cycle pulse for an out-of-range doorbell slot |

## Verification
The assertions assume the following about the inputs:
- each strobe is a single-cycle pulse;
- addresses are byte offsets on a 4-byte grid;
- at most one doorbell write and one read are presented per clock.

Under these assumptions, a write and a read may coincide on the same register. The bench drives all inputs on the falling edge and keeps strobes to one cycle. It deliberately overlaps a read with a doorbell write to the same register, so the clear-versus-set path is exercised. A second instance covers narrow mode with the same bus.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int REG_W = 32;

  function automatic int slot_count(bit narrow);
    return narrow ? 8 : 32;
  endfunction

  // bit position set by slot n of register k
  function automatic int bit_pos(int k, int n, bit narrow);
    return narrow ? (31 - 8 * k - n) : (31 - n);
  endfunction

  function automatic int reg_offset(int k, bit narrow);
    return narrow ? (16 + 4 * k) : (4 + 4 * k);
  endfunction

  function automatic logic [31:0] swap_bytes(logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction
endpackage

// File: rtl/msi_db_decode.sv
module msi_db_decode #(
  parameter int SHIFT  = 3,
  parameter bit NARROW = 1'b0,
  parameter int AW     = 8
) (
  input  logic                                   we,
  input  logic [AW-1:0]                          waddr,
  input  logic [31:0]                            wdata,
  output logic [(1<<SHIFT)*msi_agg_pkg::REG_W-1:0] set_flat,
  output logic                                   bad
);
  localparam int NREG  = 1 << SHIFT;
  localparam int NBITS = msi_agg_pkg::slot_count(NARROW);
  localparam int SW    = 32 - SHIFT;

  logic            hit;
  logic [SHIFT-1:0] sel;
  logic [SW-1:0]    slot;
  logic            in_range;
  int              pos;

  assign hit      = we && (waddr == '0);
  assign sel      = wdata[SHIFT-1:0];
  assign slot     = wdata[31:SHIFT];
  assign in_range = slot < SW'(NBITS);
  assign bad      = hit && !in_range;
  assign pos      = msi_agg_pkg::bit_pos(int'(sel), int'(slot[4:0]), NARROW);

  always_comb begin
    set_flat = '0;
    if (hit && in_range)
      set_flat[int'(sel) * msi_agg_pkg::REG_W + pos] = 1'b1;
  end

  logic unused_nreg;
  assign unused_nreg = (NREG == 0);
endmodule

// File: rtl/msi_stat_bank.sv
module msi_stat_bank #(
  parameter int NREG = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NREG*msi_agg_pkg::REG_W-1:0] set_flat,
  input  logic [NREG-1:0]                    clr_vec,
  output logic [NREG*msi_agg_pkg::REG_W-1:0] stat_flat
);
  localparam int W = msi_agg_pkg::REG_W;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        stat_flat[k*W +: W] <= '0;
      else
        stat_flat[k*W +: W] <= (clr_vec[k] ? '0 : stat_flat[k*W +: W])
                               | set_flat[k*W +: W];
    end
  end
endmodule

// File: rtl/msi_doorbell_agg.sv
module msi_doorbell_agg #(
  parameter int SHIFT  = 3,
  parameter bit NARROW = 1'b0,
  parameter int AW     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic [AW-1:0]         bus_waddr,
  input  logic [31:0]           bus_wdata,
  input  logic                  bus_re,
  input  logic [AW-1:0]         bus_raddr,
  output logic [31:0]           bus_rdata,
  output logic [(1<<SHIFT)-1:0] irq,
  output logic                  db_err
);
  localparam int NREG = 1 << SHIFT;
  localparam int W    = msi_agg_pkg::REG_W;

  logic [NREG*W-1:0] set_flat;
  logic [NREG*W-1:0] stat_flat;
  logic [NREG-1:0]   clr_vec;
  logic              dec_bad;
  logic [31:0]       rd_val;

  msi_db_decode #(.SHIFT(SHIFT), .NARROW(NARROW), .AW(AW)) u_dec (
    .we(bus_we), .waddr(bus_waddr), .wdata(bus_wdata),
    .set_flat(set_flat), .bad(dec_bad)
  );

  msi_stat_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .set_flat(set_flat),
    .clr_vec(clr_vec), .stat_flat(stat_flat)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_port
    localparam logic [AW-1:0] OFF = AW'(msi_agg_pkg::reg_offset(k, NARROW));
    assign clr_vec[k] = bus_re && (bus_raddr == OFF);
    assign irq[k]     = |stat_flat[k*W +: W];
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NREG; k++)
      if (clr_vec[k]) rd_val = stat_flat[k*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      db_err    <= 1'b0;
    end else begin
      bus_rdata <= msi_agg_pkg::swap_bytes(rd_val);
      db_err    <= dec_bad;
    end
  end
endmodule

// File: rtl/msi_agg_chk.sv
module msi_agg_chk #(
  parameter int SHIFT  = 3,
  parameter bit NARROW = 1'b0,
  parameter int AW     = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_re,
  input logic [AW-1:0]             bus_raddr,
  input logic [31:0]               bus_rdata,
  input logic [(1<<SHIFT)-1:0]     irq,
  input logic                      db_err,
  input logic [(1<<SHIFT)*32-1:0]  set_flat,
  input logic [(1<<SHIFT)*32-1:0]  stat_flat,
  input logic [(1<<SHIFT)-1:0]     clr_vec,
  input logic                      dec_bad
);
  localparam int NREG = 1 << SHIFT;

  logic [NREG*32-1:0] legal;
  always_comb begin
    legal = '0;
    for (int k = 0; k < NREG; k++)
      legal[k*32 +: 32] = NARROW ? (32'hFF << (24 - 8 * k)) : 32'hFFFF_FFFF;
  end

  AST_ONE_SET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_flat)); // R1

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
    (set_flat != '0) |=> ((stat_flat & $past(set_flat)) == $past(set_flat))); // R2

  AST_SLICE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (stat_flat & ~legal) == '0); // R6

  AST_BAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    dec_bad |=> db_err); // R7

  AST_BAD_NO_SET: assert property (@(posedge clk) disable iff (rst)
    dec_bad |-> (set_flat == '0)); // R7

  AST_DB_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_raddr == '0) |=> (bus_rdata == '0)); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0 && !db_err)); // R9

  for (genvar k = 0; k < NREG; k++) begin : g_k
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[k] && set_flat[k*32 +: 32] == '0) |=> !irq[k]); // R4

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[k]) |-> ($past(set_flat[k*32 +: 32]) != '0)); // R5
  end
endmodule

bind msi_doorbell_agg msi_agg_chk #(.SHIFT(SHIFT), .NARROW(NARROW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_re(bus_re), .bus_raddr(bus_raddr),
  .bus_rdata(bus_rdata), .irq(irq), .db_err(db_err),
  .set_flat(set_flat), .stat_flat(stat_flat), .clr_vec(clr_vec),
  .dec_bad(dec_bad)
);

// File: tb/sim_msi_doorbell_agg.sv
`timescale 1ns/1ps
module sim_msi_doorbell_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  we = '0, re = '0;
  logic [7:0]  waddr = '0, raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [7:0]  irq0;
  logic [3:0]  irq1;
  logic        err0, err1;
  int          n_chk = 0, n_err = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  msi_doorbell_agg #(.SHIFT(3), .NARROW(1'b0), .AW(8)) u0 (
    .clk(clk), .rst(rst), .bus_we(we[0]), .bus_waddr(waddr), .bus_wdata(wdata),
    .bus_re(re[0]), .bus_raddr(raddr), .bus_rdata(rdata0), .irq(irq0), .db_err(err0));

  msi_doorbell_agg #(.SHIFT(2), .NARROW(1'b1), .AW(8)) u1 (
    .clk(clk), .rst(rst), .bus_we(we[1]), .bus_waddr(waddr), .bus_wdata(wdata),
    .bus_re(re[1]), .bus_raddr(raddr), .bus_rdata(rdata1), .irq(irq1), .db_err(err1));

  // doorbell words for the normal-mode instance: register = d[2:0], slot = d[31:3]
  localparam logic [31:0] TAB [6] = '{32'd0, 32'd7, 32'd8, 32'd255, 32'h53, 32'h9E};

  function automatic logic [31:0] bsw(logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [31:0] expw(int k, int n, bit narrow);
    int b;
    b = narrow ? 31 - 8 * k - n : 31 - n;
    return bsw(32'h1 << b);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic db(int d, logic [7:0] a, logic [31:0] data);
    @(negedge clk);
    we[d] = 1'b1; waddr = a; wdata = data;
    @(negedge clk);
    we[d] = 1'b0;
  endtask

  task automatic rd(int d, logic [7:0] a, output logic [31:0] val);
    @(negedge clk);
    re[d] = 1'b1; raddr = a;
    @(negedge clk);
    re[d] = 1'b0;
    val = (d == 0) ? rdata0 : rdata1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 irq0", 32'(irq0), 0);
    check("R9 irq1", 32'(irq1), 0);
    check("R9 err", {30'd0, err1, err0}, 0);
    rd(0, 8'h04, v); check("R9 reg0 empty", v, 0);

    // R1 R2 R3 R4 R5 table walk on normal instance
    for (int i = 0; i < 6; i++) begin
      int k, n;
      k = int'(TAB[i][2:0]);
      n = int'(TAB[i] >> 3);
      db(0, 8'h00, TAB[i]);
      check("R5 irq up", 32'(irq0[k]), 1);
      check("R1 only one line", 32'($countones(irq0)), 1);
      rd(0, 8'(4 + 4 * k), v);
      check("R2 R3 read value", v, expw(k, n, 1'b0));
      check("R4 R5 cleared", 32'(irq0[k]), 0);
    end

    // R2 accumulate two slots in register 1
    db(0, 8'h00, 32'h01);
    db(0, 8'h00, 32'h09);
    rd(0, 8'h08, v); check("R2 accumulate", v, bsw(32'hC000_0000));

    // R4 same-cycle read and doorbell on register 2
    db(0, 8'h00, 32'h2A);
    @(negedge clk);
    re[0] = 1'b1; raddr = 8'h0C; we[0] = 1'b1; waddr = 8'h00; wdata = 32'h32;
    @(negedge clk);
    re[0] = 1'b0; we[0] = 1'b0;
    check("R4 old value", rdata0, expw(2, 5, 1'b0));
    check("R4 survivor irq", 32'(irq0[2]), 1);
    rd(0, 8'h0C, v); check("R4 survivor value", v, expw(2, 6, 1'b0));

    // R7 out-of-range slot on normal instance
    @(negedge clk);
    we[0] = 1'b1; waddr = 8'h00; wdata = 32'd256;
    @(negedge clk);
    we[0] = 1'b0;
    check("R7 err pulse", 32'(err0), 1);
    check("R7 no irq", 32'(irq0), 0);
    @(negedge clk);
    check("R7 err one cycle", 32'(err0), 0);

    // R8 doorbell/unmapped reads and non-doorbell writes
    db(0, 8'h00, 32'h03);
    rd(0, 8'h00, v); check("R8 doorbell read zero", v, 0);
    rd(0, 8'h40, v); check("R8 unmapped read zero", v, 0);
    check("R8 nothing cleared", 32'(irq0[3]), 1);
    db(0, 8'h04, 32'h04);
    check("R8 write elsewhere ignored", 32'(irq0), 32'h08);
    rd(0, 8'h10, v); check("R8 reg3 value", v, bsw(32'h8000_0000));

    // R6 narrow instance
    db(1, 8'h00, 32'h0D);
    check("R6 narrow irq", 32'(irq1), 32'h2);
    rd(1, 8'h04, v); check("R3 narrow old offset empty", v, 0);
    rd(1, 8'h14, v); check("R6 narrow k1 n3", v, expw(1, 3, 1'b1));
    db(1, 8'h00, 32'h1F);
    rd(1, 8'h1C, v); check("R6 narrow k3 n7", v, expw(3, 7, 1'b1));
    db(1, 8'h00, 32'h00);
    rd(1, 8'h10, v); check("R6 narrow k0 n0", v, expw(0, 0, 1'b1));
    @(negedge clk);
    we[1] = 1'b1; waddr = 8'h00; wdata = 32'h20;
    @(negedge clk);
    we[1] = 1'b0;
    check("R7 narrow err", 32'(err1), 1);
    check("R7 narrow no irq", 32'(irq1), 0);

    // R9 reset while pending
    db(0, 8'h00, 32'h05);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 reset clears", 32'(irq0), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule